// File: doc/BRIEF.md
# Transceiver Reconfiguration Request Arbiter

A transceiver channel that carries a receive path and a transmit path has a single reconfiguration port. Often the two paths are driven by independent controllers, each with its own memory-mapped reconfiguration master. This block sits between those two masters and the channel. It admits one access at a time onto the shared port and hands the read data and wait state back only to the master that issued the access.

The channel raises one calibration-busy flag for the whole channel. The arbiter remembers which side started the current access and keeps that ownership until the access has finished and the channel has dropped busy. It gives the busy flag to the owner alone and holds the other side's flag low. The idle direction therefore never sees a calibration it did not ask for. A side whose master is tied off never gains ownership and never disturbs the other side.

Ties between the two sides are resolved by alternating priority by default. A parameter selects a fixed receive-first variant instead.

Top module: `xcvr_cfg_arbiter`

## Requirements
- R1: After reset is released, no side owns the channel. Both gated busy outputs are 0 and neither channel strobe (read or write) is asserted, whatever the channel busy input is.
- R2: No more than one side's access is ever forwarded to the channel. The forwarded address, write data and strobes are those of the owning side only.
- R3: While the receive side owns the channel, the transmit busy output is 0 and the receive busy output equals the channel busy input.
- R4: While the transmit side owns the channel, the receive busy output is 0 and the transmit busy output equals the channel busy input.
- R5: When both sides raise a request in the same idle cycle, the side that did not win the previous grant wins (the receive side wins the first tie after reset). The loser keeps waitrequest at 1 until it is granted.
- R6: After the owner's access completes, ownership is kept for as long as the channel busy input stays 1. During that time the other side's request stays stalled with waitrequest at 1.
- R7: Channel read data and waitrequest reach only the owner during its access. The other side sees waitrequest 1 and read data 0.
- R8: When no access is in progress and the owner's busy has fallen, the arbiter returns to idle. In idle both busy outputs are 0.
- R9: A request that arrives while the arbiter is idle is stalled for exactly one cycle (waitrequest 1, no channel strobe). In the following cycle it appears on the channel with its address and write data unchanged.
- R10: A side whose read and write inputs are held at 0 has no effect on the other side. The active side's writes are stored and its reads return the stored data.
- R11: If the owner issues a new request while it still holds the channel, it is forwarded without arbitration, ahead of a pending request from the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_addr | input | ADDR_W | Receive-side word address |
| rx_read | input | 1 | Receive-side read request |
| rx_write | input | 1 | Receive-side write request |
| rx_wdata | input | DATA_W | Receive-side write data |
| rx_rdata | output | DATA_W | Read data returned to the receive side |
| rx_waitreq | output | 1 | Stall to the receive side |
| rx_cal_busy | output | 1 | Calibration busy gated for the receive side |
| tx_addr | input | ADDR_W | Transmit-side word address |
| tx_read | input | 1 | Transmit-side read request |
| tx_write | input | 1 | Transmit-side write request |
| tx_wdata | input | DATA_W | Transmit-side write data |
| tx_rdata | output | DATA_W | Read data returned to the transmit side |
| tx_waitreq | output | 1 | Stall to the transmit side |
| tx_cal_busy | output | 1 | Calibration busy gated for the transmit side |
| ch_addr | output | ADDR_W | Address to the channel port |
| ch_read | output | 1 | Read strobe to the channel |
| ch_write | output | 1 | Write strobe to the channel |
| ch_wdata | output | DATA_W | Write data to the channel |
| ch_rdata | input | DATA_W | Read data from the channel |
| ch_waitreq | input | 1 | Stall from the channel |
| ch_cal_busy | input | 1 | Channel calibration busy |

## Verification
The assertions assume that each master behaves as a memory-mapped master should. It never raises read and write together. It holds its address, data and strobe steady while its waitrequest is 1. It drops the strobe only after a cycle in which waitrequest was 0. The bench's access task drives both sides this way. The channel model in the bench answers every forwarded access within a bounded number of wait cycles, and raises busy only for short bursts after writes, so ownership always comes back to idle. Random traffic keeps each side inside its own half of the address space, so read-back checks stay valid while both sides run at once.

// File: rtl/xcvr_cfg_pkg.sv
package xcvr_cfg_pkg;

   localparam int NUM_SIDES = 2;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_HOLD   = 2'd2
   } arb_state_e;

   typedef enum logic {
      SIDE_RX = 1'b0,
      SIDE_TX = 1'b1
   } side_e;

endpackage

// File: rtl/xcvr_cfg_pick.sv
module xcvr_cfg_pick
   import xcvr_cfg_pkg::*;
#(
   parameter bit RR_EN = 1'b1
) (
   input  logic [NUM_SIDES-1:0] req,
   input  side_e                last_win,
   output side_e                win
);

   generate
      if (RR_EN) begin : g_rr
         // on a tie the side that lost last time goes first
         always_comb begin
            if (req[SIDE_RX] && req[SIDE_TX]) begin
               win = (last_win == SIDE_RX) ? SIDE_TX : SIDE_RX;
            end else if (req[SIDE_TX]) begin
               win = SIDE_TX;
            end else begin
               win = SIDE_RX;
            end
         end
      end else begin : g_fixed
         always_comb begin
            win = req[SIDE_RX] ? SIDE_RX : (req[SIDE_TX] ? SIDE_TX : SIDE_RX);
         end
      end
   endgenerate

endmodule

// File: rtl/xcvr_cfg_ctrl.sv
module xcvr_cfg_ctrl
   import xcvr_cfg_pkg::*;
#(
   parameter bit RR_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SIDES-1:0] req,
   input  logic                 ch_waitreq,
   input  logic                 ch_cal_busy,
   output arb_state_e           state,
   output side_e                owner
);

   arb_state_e state_q, state_d;
   side_e      owner_q, owner_d;
   side_e      last_q,  last_d;
   side_e      pick_win;
   logic       owner_req;

   xcvr_cfg_pick #(.RR_EN(RR_EN)) u_pick (
      .req      (req),
      .last_win (last_q),
      .win      (pick_win)
   );

   assign owner_req = req[owner_q];

   always_comb begin
      state_d = state_q;
      owner_d = owner_q;
      last_d  = last_q;
      unique case (state_q)
         ST_IDLE: begin
            if (|req) begin
               state_d = ST_ACCESS;
               owner_d = pick_win;
               last_d  = pick_win;
            end
         end
         ST_ACCESS: begin
            // completion (or a withdrawn strobe) ends the access
            if (!owner_req || !ch_waitreq) begin
               state_d = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (owner_req) begin
               state_d = ST_ACCESS;
            end else if (!ch_cal_busy) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         owner_q <= SIDE_RX;
         last_q  <= SIDE_TX;
      end else begin
         state_q <= state_d;
         owner_q <= owner_d;
         last_q  <= last_d;
      end
   end

   assign state = state_q;
   assign owner = owner_q;

endmodule

// File: rtl/xcvr_cfg_path.sv
module xcvr_cfg_path
   import xcvr_cfg_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  arb_state_e                        state,
   input  side_e                             owner,
   input  logic [NUM_SIDES-1:0][ADDR_W-1:0]  s_addr,
   input  logic [NUM_SIDES-1:0]              s_read,
   input  logic [NUM_SIDES-1:0]              s_write,
   input  logic [NUM_SIDES-1:0][DATA_W-1:0]  s_wdata,
   output logic [NUM_SIDES-1:0][DATA_W-1:0]  s_rdata,
   output logic [NUM_SIDES-1:0]              s_waitreq,
   output logic [ADDR_W-1:0]                 ch_addr,
   output logic                              ch_read,
   output logic                              ch_write,
   output logic [DATA_W-1:0]                 ch_wdata,
   input  logic [DATA_W-1:0]                 ch_rdata,
   input  logic                              ch_waitreq
);

   logic active;

   assign active   = (state == ST_ACCESS);
   assign ch_addr  = s_addr[owner];
   assign ch_wdata = s_wdata[owner];
   assign ch_read  = active && s_read[owner];
   assign ch_write = active && s_write[owner];

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         logic served;
         assign served       = active && (owner == side_e'(s));
         assign s_rdata[s]   = served ? ch_rdata : '0;
         assign s_waitreq[s] = served ? ch_waitreq : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/xcvr_cfg_busy_gate.sv
module xcvr_cfg_busy_gate
   import xcvr_cfg_pkg::*;
(
   input  arb_state_e           state,
   input  side_e                owner,
   input  logic                 ch_cal_busy,
   output logic [NUM_SIDES-1:0] side_busy
);

   logic owned;

   assign owned = (state != ST_IDLE);

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_gate
         assign side_busy[s] = ch_cal_busy && owned && (owner == side_e'(s));
      end
   endgenerate

endmodule

// File: rtl/xcvr_cfg_arbiter.sv
module xcvr_cfg_arbiter
   import xcvr_cfg_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter bit RR_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic              rx_read,
   input  logic              rx_write,
   input  logic [DATA_W-1:0] rx_wdata,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              rx_waitreq,
   output logic              rx_cal_busy,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_read,
   input  logic              tx_write,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic [DATA_W-1:0] tx_rdata,
   output logic              tx_waitreq,
   output logic              tx_cal_busy,
   output logic [ADDR_W-1:0] ch_addr,
   output logic              ch_read,
   output logic              ch_write,
   output logic [DATA_W-1:0] ch_wdata,
   input  logic [DATA_W-1:0] ch_rdata,
   input  logic              ch_waitreq,
   input  logic              ch_cal_busy
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("xcvr_cfg_arbiter: ADDR_W must lie in 1..32");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("xcvr_cfg_arbiter: DATA_W must lie in 1..64");
   end

   logic [NUM_SIDES-1:0][ADDR_W-1:0] s_addr;
   logic [NUM_SIDES-1:0]             s_read;
   logic [NUM_SIDES-1:0]             s_write;
   logic [NUM_SIDES-1:0][DATA_W-1:0] s_wdata;
   logic [NUM_SIDES-1:0][DATA_W-1:0] s_rdata;
   logic [NUM_SIDES-1:0]             s_waitreq;
   logic [NUM_SIDES-1:0]             s_req;
   logic [NUM_SIDES-1:0]             side_busy;
   arb_state_e                       state;
   side_e                            owner;

   assign s_addr[SIDE_RX]  = rx_addr;
   assign s_addr[SIDE_TX]  = tx_addr;
   assign s_read[SIDE_RX]  = rx_read;
   assign s_read[SIDE_TX]  = tx_read;
   assign s_write[SIDE_RX] = rx_write;
   assign s_write[SIDE_TX] = tx_write;
   assign s_wdata[SIDE_RX] = rx_wdata;
   assign s_wdata[SIDE_TX] = tx_wdata;
   assign s_req            = s_read | s_write;

   xcvr_cfg_ctrl #(.RR_EN(RR_EN)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (s_req),
      .ch_waitreq  (ch_waitreq),
      .ch_cal_busy (ch_cal_busy),
      .state       (state),
      .owner       (owner)
   );

   xcvr_cfg_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
      .state      (state),
      .owner      (owner),
      .s_addr     (s_addr),
      .s_read     (s_read),
      .s_write    (s_write),
      .s_wdata    (s_wdata),
      .s_rdata    (s_rdata),
      .s_waitreq  (s_waitreq),
      .ch_addr    (ch_addr),
      .ch_read    (ch_read),
      .ch_write   (ch_write),
      .ch_wdata   (ch_wdata),
      .ch_rdata   (ch_rdata),
      .ch_waitreq (ch_waitreq)
   );

   xcvr_cfg_busy_gate u_gate (
      .state       (state),
      .owner       (owner),
      .ch_cal_busy (ch_cal_busy),
      .side_busy   (side_busy)
   );

   assign rx_rdata    = s_rdata[SIDE_RX];
   assign tx_rdata    = s_rdata[SIDE_TX];
   assign rx_waitreq  = s_waitreq[SIDE_RX];
   assign tx_waitreq  = s_waitreq[SIDE_TX];
   assign rx_cal_busy = side_busy[SIDE_RX];
   assign tx_cal_busy = side_busy[SIDE_TX];

endmodule

// File: rtl/xcvr_cfg_arbiter_chk.sv
module xcvr_cfg_arbiter_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_read,
   input logic              rx_write,
   input logic [DATA_W-1:0] rx_rdata,
   input logic              rx_waitreq,
   input logic              rx_cal_busy,
   input logic              tx_read,
   input logic              tx_write,
   input logic [DATA_W-1:0] tx_rdata,
   input logic              tx_waitreq,
   input logic              tx_cal_busy,
   input logic [ADDR_W-1:0] ch_addr,
   input logic              ch_read,
   input logic              ch_write,
   input logic [DATA_W-1:0] ch_rdata,
   input logic              ch_waitreq,
   input logic              ch_cal_busy
);

   logic rx_req, tx_req;
   assign rx_req = rx_read || rx_write;
   assign tx_req = tx_read || tx_write;

   // R1
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!rx_cal_busy && !tx_cal_busy && !ch_read && !ch_write));

   // R2
   a_r2_single_service: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_req && !rx_waitreq && tx_req && !tx_waitreq));

   // R2: a strobe on the channel always belongs to some requesting side
   a_r2_strobe_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_read || ch_write) |-> (rx_req || tx_req));

   // R3 and R4
   a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rx_cal_busy, tx_cal_busy}) <= 1);

   // R4
   a_r4_busy_from_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cal_busy || tx_cal_busy) |-> ch_cal_busy);

   // R6: the rx owner keeps the channel while busy stays high
   a_r6_rx_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rx_cal_busy) && ch_cal_busy) |-> !tx_cal_busy);

   // R6
   a_r6_tx_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_cal_busy) && ch_cal_busy) |-> !rx_cal_busy);

   // R5
   a_r5_tie_one_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && tx_req) |-> (rx_waitreq || tx_waitreq));

   // R7
   a_r7_rx_data_on_service: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && !rx_waitreq) |-> (rx_rdata == ch_rdata && ch_waitreq == 1'b0));

   // R7
   a_r7_tx_data_on_service: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_waitreq) |-> (tx_rdata == ch_rdata && ch_waitreq == 1'b0));

   // R9: a request newly raised is stalled in that cycle
   a_r9_first_cycle_stall: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_req) && !$past(rx_cal_busy) && !$past(tx_cal_busy) && !tx_req
       && !$past(tx_req)) |-> rx_waitreq);

endmodule

bind xcvr_cfg_arbiter xcvr_cfg_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_read     (rx_read),
   .rx_write    (rx_write),
   .rx_rdata    (rx_rdata),
   .rx_waitreq  (rx_waitreq),
   .rx_cal_busy (rx_cal_busy),
   .tx_read     (tx_read),
   .tx_write    (tx_write),
   .tx_rdata    (tx_rdata),
   .tx_waitreq  (tx_waitreq),
   .tx_cal_busy (tx_cal_busy),
   .ch_addr     (ch_addr),
   .ch_read     (ch_read),
   .ch_write    (ch_write),
   .ch_rdata    (ch_rdata),
   .ch_waitreq  (ch_waitreq),
   .ch_cal_busy (ch_cal_busy)
);

// File: tb/xcvr_cfg_arbiter_bench.sv
`timescale 1ns/1ps
module xcvr_cfg_arbiter_bench;

   localparam int AW = 6;
   localparam int DW = 32;
   localparam int MEMN = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0] rx_addr = '0, tx_addr = '0;
   logic rx_read = 0, rx_write = 0, tx_read = 0, tx_write = 0;
   logic [DW-1:0] rx_wdata = '0, tx_wdata = '0;
   logic [DW-1:0] rx_rdata, tx_rdata, ch_rdata, ch_wdata;
   logic rx_waitreq, tx_waitreq, rx_cal_busy, tx_cal_busy;
   logic [AW-1:0] ch_addr;
   logic ch_read, ch_write, ch_waitreq, ch_cal_busy;

   xcvr_cfg_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_xcvr_cfg_arbiter (
      .clk(clk), .rst_n(rst_n),
      .rx_addr(rx_addr), .rx_read(rx_read), .rx_write(rx_write), .rx_wdata(rx_wdata),
      .rx_rdata(rx_rdata), .rx_waitreq(rx_waitreq), .rx_cal_busy(rx_cal_busy),
      .tx_addr(tx_addr), .tx_read(tx_read), .tx_write(tx_write), .tx_wdata(tx_wdata),
      .tx_rdata(tx_rdata), .tx_waitreq(tx_waitreq), .tx_cal_busy(tx_cal_busy),
      .ch_addr(ch_addr), .ch_read(ch_read), .ch_write(ch_write), .ch_wdata(ch_wdata),
      .ch_rdata(ch_rdata), .ch_waitreq(ch_waitreq), .ch_cal_busy(ch_cal_busy)
   );

   // channel model
   logic [DW-1:0] mem [MEMN];
   logic [DW-1:0] shadow [MEMN];
   int  wcnt = 0;
   int  lat_max = 0;
   int  busy_cnt = 0;
   bit  busy_force = 0;
   bit  rnd_busy = 0;

   assign ch_waitreq  = (wcnt != 0);
   assign ch_rdata    = mem[ch_addr];
   assign ch_cal_busy = busy_force || (busy_cnt != 0);

   always @(posedge clk) begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (ch_read || ch_write) begin
         if (wcnt != 0) begin
            wcnt <= wcnt - 1;
         end else begin
            if (ch_write) mem[ch_addr] <= ch_wdata;
            wcnt <= $urandom_range(lat_max, 0);
            if (ch_write && rnd_busy && ($urandom % 3 == 0))
               busy_cnt <= $urandom_range(6, 1);
         end
      end
   end

   int  checks = 0;
   int  failures = 0;
   int  mon_err = 0;
   bit  mon_on = 0;
   bit  done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] side_addr(input bit side, input logic [AW-2:0] low);
      return {side, low};
   endfunction

   always @(negedge clk) begin
      if (mon_on) begin
         if ((rx_cal_busy || tx_cal_busy) && !ch_cal_busy) mon_err++;
         if (rx_cal_busy && tx_cal_busy) mon_err++;
         if ((rx_read || rx_write) && !rx_waitreq && (tx_read || tx_write) && !tx_waitreq)
            mon_err++;
      end
   end

   task automatic acc(input bit side, input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd);
      @(negedge clk);
      if (!side) begin
         rx_addr = a; rx_wdata = d; rx_write = wr; rx_read = !wr;
      end else begin
         tx_addr = a; tx_wdata = d; tx_write = wr; tx_read = !wr;
      end
      #1;
      while (side ? tx_waitreq : rx_waitreq) begin
         @(negedge clk); #1;
      end
      rd = side ? tx_rdata : rx_rdata;
      @(negedge clk);
      if (!side) begin rx_read = 0; rx_write = 0; end
      else begin tx_read = 0; tx_write = 0; end
   endtask

   task automatic rand_run(input bit side, input int n, input string tag);
      logic [DW-1:0] rd;
      for (int i = 0; i < n; i++) begin
         bit wr = bit'($urandom % 2);
         logic [AW-1:0] a = side_addr(side, AW'($urandom) & {1'b0, {(AW-1){1'b1}}});
         logic [DW-1:0] d = $urandom;
         acc(side, wr, a, d, rd);
         if (wr) shadow[a] = d;
         else chk(tag, rd, shadow[a]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      logic [DW-1:0] d1;
      void'($urandom(32'd4711));
      for (int i = 0; i < MEMN; i++) begin mem[i] = '0; shadow[i] = '0; end
      d1 = 32'hA5A5_0001;

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 / R8: idle with channel busy high
      @(negedge clk); busy_force = 1; #1;
      chk("R1 rx_cal_busy", rx_cal_busy, 0);
      chk("R1 tx_cal_busy", tx_cal_busy, 0);
      chk("R1 strobes", {ch_read, ch_write}, 0);
      chk("R8 idle busy gated", {rx_cal_busy, tx_cal_busy}, 0);
      @(negedge clk); busy_force = 0;

      // R9 / R3 / R6: rx write then busy, tx waits
      @(negedge clk); rx_write = 1; rx_addr = 6'h05; rx_wdata = d1; #1;
      chk("R9 stall first cycle", rx_waitreq, 1);
      chk("R9 no strobe yet", ch_write, 0);
      @(negedge clk); #1;
      chk("R9 write forwarded", ch_write, 1);
      chk("R2 address of owner", ch_addr, 6'h05);
      chk("R9 wdata forwarded", ch_wdata, d1);
      chk("R7 owner waitreq", rx_waitreq, 0);
      shadow[5] = d1;
      @(negedge clk); rx_write = 0; busy_force = 1; tx_read = 1; tx_addr = 6'h05; #1;
      chk("R3 rx busy follows", rx_cal_busy, 1);
      chk("R3 tx busy gated", tx_cal_busy, 0);
      chk("R6 tx stalled", tx_waitreq, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R6 tx stalled while busy", {tx_waitreq, ch_read, rx_cal_busy}, 3'b101);
      end
      @(negedge clk); busy_force = 0; #1;
      chk("R8 busy low while held", {rx_cal_busy, tx_cal_busy}, 0);
      @(negedge clk); #1;
      chk("R8 idle tx stalled", tx_waitreq, 1);
      @(negedge clk); busy_force = 1; #1;
      chk("R4 tx read forwarded", ch_read, 1);
      chk("R7 tx served", tx_waitreq, 0);
      chk("R7 tx read data", tx_rdata, d1);
      chk("R4 tx busy follows", tx_cal_busy, 1);
      chk("R4 rx busy gated", rx_cal_busy, 0);
      @(negedge clk); tx_read = 0; #1;
      chk("R4 tx keeps busy", {tx_cal_busy, rx_cal_busy}, 2'b10);
      busy_force = 0;
      @(negedge clk); #1;
      chk("R8 returns idle", {tx_cal_busy, rx_cal_busy}, 0);

      // R5: tie after a tx grant -> rx wins
      @(negedge clk); rx_read = 1; rx_addr = 6'h05; tx_read = 1; tx_addr = 6'h21; #1;
      chk("R5 both stalled in idle", {rx_waitreq, tx_waitreq}, 2'b11);
      @(negedge clk); #1;
      chk("R5 rx wins tie", ch_addr, 6'h05);
      chk("R5 loser stalled", tx_waitreq, 1);
      chk("R7 loser data zero", tx_rdata, 0);
      chk("R7 winner data", rx_rdata, d1);
      @(negedge clk); rx_read = 0; #1;
      chk("R5 loser still stalled", tx_waitreq, 1);
      @(negedge clk); #1;
      chk("R5 loser stalled idle", tx_waitreq, 1);
      @(negedge clk); #1;
      chk("R5 loser granted", {ch_addr, tx_waitreq}, {6'h21, 1'b0});
      @(negedge clk); tx_read = 0;

      // R5: tie after an rx grant -> tx wins
      acc(0, 0, 6'h05, '0, rd);
      @(negedge clk); @(negedge clk);
      rx_read = 1; rx_addr = 6'h06; tx_read = 1; tx_addr = 6'h22;
      @(negedge clk); #1;
      chk("R5 tx wins alternate tie", {ch_addr, rx_waitreq}, {6'h22, 1'b1});
      @(negedge clk); tx_read = 0;
      @(negedge clk); @(negedge clk); #1;
      chk("R5 rx granted after", {ch_addr, rx_waitreq}, {6'h06, 1'b0});
      @(negedge clk); rx_read = 0;

      // R11: owner re-request during hold beats pending tx
      @(negedge clk); busy_force = 1;
      acc(0, 1, 6'h07, 32'h1234_5678, rd);
      shadow[7] = 32'h1234_5678;
      tx_read = 1; tx_addr = 6'h22; #1;
      chk("R11 tx stalled during hold", tx_waitreq, 1);
      @(negedge clk); rx_read = 1; rx_addr = 6'h07;
      @(negedge clk); #1;
      chk("R11 owner forwarded", {ch_addr, rx_waitreq, tx_waitreq}, {6'h07, 1'b0, 1'b1});
      chk("R11 owner data", rx_rdata, 32'h1234_5678);
      @(negedge clk); rx_read = 0; busy_force = 0;
      @(negedge clk);
      @(negedge clk); #1;
      chk("R11 tx served after", {ch_addr, tx_waitreq}, {6'h22, 1'b0});
      @(negedge clk); tx_read = 0;

      // R10: tx tied off, rx random traffic with wait states and busy bursts
      lat_max = 2; rnd_busy = 1; mon_on = 1;
      rand_run(0, 60, "R10 rx read-back, tx idle");

      // R2 / R7: both sides at once
      fork
         rand_run(0, 150, "R2 rx read-back concurrent");
         rand_run(1, 150, "R7 tx read-back concurrent");
      join
      repeat (10) @(negedge clk);
      mon_on = 0;
      chk("R3 R4 busy gating monitor", mon_err, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule